// File: doc/BRIEF.md
# SPI Host Interrupt and Error Reporting

This block gathers the error and event conditions of a memory-mapped SPI host controller into two interrupt lines. One line reports errors and the other reports events. Each class has a master enable bit and a test bit, and it has its own mask that selects which of its sources may raise it. Once a class is raised, its pending bit stays set until software clears it by writing a 1.

The rest of the controller supplies single-cycle error pulses and level-type event flags. The block latches the error pulses into a sticky status register whether or not they are enabled. The enable masks only decide whether a latched error or an active event may raise an interrupt. Software writes the registers through a simple write port made of a strobe, a word address and data. It reads them back through a combinational read port.

Register map, by word address: 0 pending state (write 1 to clear), 1 class enable, 2 class test, 3 error mask, 4 error status (write 1 to clear), 5 event mask. All other addresses read as zero and ignore writes. In the three class registers, bit 0 is the error class and bit 1 is the event class.

Top module: `spi_irq_agg`

## Requirements
- R1: After reset, the error mask reads 0x1F. The pending state, class enable, class test, error status and event mask read 0, and both interrupt outputs are low.
- R2: A pulse on `err_pulse[i]` sets error status bit i on the next clock edge, whatever the masks and enables hold. The bits are 0 command-busy, 1 overflow, 2 underflow, 3 invalid command, 4 invalid chip-select ID and 5 invalid access. A set bit stays set.
- R3: Writing 1 to an error status bit clears it. When a write of 1 and a pulse hit the same bit in the same cycle, the bit ends up set.
- R4: When class-enable bit 0 is set and an error status bit whose error mask bit is also set is 1, pending bit 0 sets on the following edge. An error status bit whose mask bit is clear raises nothing.
- R5: When class-enable bit 1 is set and an `evt_level` bit whose event mask bit is also set is 1, pending bit 1 sets on the following edge. The event bits are 0 RX full, 1 TX empty, 2 RX watermark, 3 TX watermark, 4 ready and 5 idle. An unmasked event raises nothing.
- R6: When a class's test bit and its enable bit are both set, that class's pending bit sets on the next edge with no source active.
- R7: While a class's enable bit is clear, its pending bit does not become set, not even from its test bit.
- R8: A pending bit stays set after its sources go away, and after the error status is cleared, until software writes 1 to it.
- R9: Each interrupt output is a register that holds the pending bit ANDed with the class enable bit as they stood one cycle earlier. Clearing the enable bit drops the output one cycle after the write, and the pending bit stays set.
- R10: Writing 1 to a pending bit clears it on that edge. If the raising condition is still present, the bit sets again on the next edge.
- R11: Writes to word addresses 6 to 15 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 6 | Write data |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 6 | Read data, combinational |
| err_pulse | input | 6 | Single-cycle error pulses from the controller |
| evt_level | input | 6 | Level event flags from the controller |
| irq_err | output | 1 | Error interrupt line |
| irq_evt | output | 1 | Event interrupt line |

## Verification
The error path is driven with pulses on a masked bit, on an unmasked bit, and on the invalid-access bit, which the reset mask leaves off. These cases separate capture into status from the raising of an interrupt. A pulse and a clear that land on the same cycle show which of the two wins. The event path is driven with an active flag outside the mask and then with one inside it. The event flag is held while its pending bit is cleared, which shows re-raising apart from stickiness. The test bits are tried both with the class enabled and with it disabled. Dropping an enable while an interrupt is pending separates the registered output from the pending state. Writes to unused addresses complete the set.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int NUM_ERR = 6;
  localparam int NUM_EVT = 6;
  localparam int REG_W = (NUM_ERR > NUM_EVT) ? NUM_ERR : NUM_EVT;
  localparam int NUM_CLS = 2;

  localparam logic [ADDR_W-1:0] A_STATE   = 4'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_TEST    = 4'd2;
  localparam logic [ADDR_W-1:0] A_ERR_EN  = 4'd3;
  localparam logic [ADDR_W-1:0] A_ERR_ST  = 4'd4;
  localparam logic [ADDR_W-1:0] A_EVT_EN  = 4'd5;

  localparam logic [NUM_ERR-1:0] ERR_EN_RST = 6'h1F;

  // sticky write-1-to-clear update: a new set beats a clear in the same cycle
  function automatic logic [REG_W-1:0] w1c_vec(input logic [REG_W-1:0] cur,
                                               input logic [REG_W-1:0] set,
                                               input logic [REG_W-1:0] clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic w1c_bit(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [NUM_CLS-1:0]   pending,
  input  logic [NUM_ERR-1:0]   err_status,
  output logic [REG_W-1:0]     rd_data,
  output logic [NUM_CLS-1:0]   cls_en,
  output logic [NUM_CLS-1:0]   cls_test,
  output logic [NUM_ERR-1:0]   err_mask,
  output logic [NUM_EVT-1:0]   evt_mask,
  output logic [NUM_CLS-1:0]   state_clr,
  output logic [NUM_ERR-1:0]   err_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_en   <= '0;
      cls_test <= '0;
      err_mask <= ERR_EN_RST;
      evt_mask <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_ENABLE: cls_en   <= wr_data[NUM_CLS-1:0];
        A_TEST:   cls_test <= wr_data[NUM_CLS-1:0];
        A_ERR_EN: err_mask <= wr_data[NUM_ERR-1:0];
        A_EVT_EN: evt_mask <= wr_data[NUM_EVT-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    state_clr = (wr_en && wr_addr == A_STATE)  ? wr_data[NUM_CLS-1:0] : '0;
    err_clr   = (wr_en && wr_addr == A_ERR_ST) ? wr_data[NUM_ERR-1:0] : '0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_STATE:  rd_data[NUM_CLS-1:0] = pending;
      A_ENABLE: rd_data[NUM_CLS-1:0] = cls_en;
      A_TEST:   rd_data[NUM_CLS-1:0] = cls_test;
      A_ERR_EN: rd_data[NUM_ERR-1:0] = err_mask;
      A_ERR_ST: rd_data[NUM_ERR-1:0] = err_status;
      A_EVT_EN: rd_data[NUM_EVT-1:0] = evt_mask;
      default: ;
    endcase
  end

  // R11: an unmapped write leaves every control register unchanged
  a_r11_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > A_EVT_EN) |=> ($stable(cls_en) && $stable(cls_test)
                                       && $stable(err_mask) && $stable(evt_mask)));
endmodule

// File: rtl/spi_irq_err_status.sv
module spi_irq_err_status
  import spi_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] err_pulse,
  input  logic [NUM_ERR-1:0] err_clr,
  output logic [NUM_ERR-1:0] err_status
);
  logic [REG_W-1:0] next_w;

  always_comb next_w = w1c_vec(REG_W'(err_status), REG_W'(err_pulse), REG_W'(err_clr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_status <= '0;
    else        err_status <= next_w[NUM_ERR-1:0];
  end

  // R2: every pulsed bit is set one cycle later, masks play no part
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |=> ((err_status & $past(err_pulse)) == $past(err_pulse)));

  // R3: a cleared bit with no competing pulse reads zero afterwards
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_clr & ~err_pulse)) |=> ((err_status & $past(err_clr & ~err_pulse)) == '0));

  // R2: bits not cleared never fall
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr == '0) |=> ((err_status & $past(err_status)) == $past(err_status)));
endmodule

// File: rtl/spi_irq_class.sv
module spi_irq_class
  import spi_irq_pkg::*;
#(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cls_en,
  input  logic            cls_test,
  input  logic [NSRC-1:0] src_act,
  input  logic [NSRC-1:0] src_mask,
  input  logic            clr,
  output logic            pending,
  output logic            irq
);
  logic src_hit;
  logic raise;

  assign src_hit = |(src_act & src_mask);
  assign raise   = cls_en & ~pending & (cls_test | src_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      irq     <= 1'b0;
    end else begin
      pending <= w1c_bit(pending, raise, clr);
      irq     <= pending & cls_en;
    end
  end

  // R8: pending holds until written with a 1
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> pending);

  // R7: a disabled class never becomes pending
  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !cls_en) |=> !pending);

  // R6: the test bit alone raises an enabled class
  a_r6_test_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_en && cls_test && !pending) |=> pending);

  // R9: output falls one cycle after the enable is cleared
  a_r9_en_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_en |=> !irq);

  // R9: output rises only after pending was already set
  a_r9_rise_after_pend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pending));
endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
  import spi_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [REG_W-1:0]   rd_data,
  input  logic [NUM_ERR-1:0] err_pulse,
  input  logic [NUM_EVT-1:0] evt_level,
  output logic               irq_err,
  output logic               irq_evt
);
  logic [NUM_CLS-1:0] cls_en;
  logic [NUM_CLS-1:0] cls_test;
  logic [NUM_CLS-1:0] state_clr;
  logic [NUM_CLS-1:0] pending;
  logic [NUM_CLS-1:0] irq_vec;
  logic [NUM_ERR-1:0] err_mask;
  logic [NUM_ERR-1:0] err_clr;
  logic [NUM_ERR-1:0] err_status;
  logic [NUM_EVT-1:0] evt_mask;

  // class 0 = error, class 1 = event
  logic [NUM_CLS-1:0][REG_W-1:0] src_act;
  logic [NUM_CLS-1:0][REG_W-1:0] src_mask;

  always_comb begin
    src_act[0]  = REG_W'(err_status);
    src_mask[0] = REG_W'(err_mask);
    src_act[1]  = REG_W'(evt_level);
    src_mask[1] = REG_W'(evt_mask);
  end

  spi_irq_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .pending    (pending),
    .err_status (err_status),
    .rd_data    (rd_data),
    .cls_en     (cls_en),
    .cls_test   (cls_test),
    .err_mask   (err_mask),
    .evt_mask   (evt_mask),
    .state_clr  (state_clr),
    .err_clr    (err_clr)
  );

  spi_irq_err_status u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_pulse  (err_pulse),
    .err_clr    (err_clr),
    .err_status (err_status)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    spi_irq_class #(.NSRC(REG_W)) u_cls (
      .clk      (clk),
      .rst_n    (rst_n),
      .cls_en   (cls_en[c]),
      .cls_test (cls_test[c]),
      .src_act  (src_act[c]),
      .src_mask (src_mask[c]),
      .clr      (state_clr[c]),
      .pending  (pending[c]),
      .irq      (irq_vec[c])
    );
  end

  assign irq_err = irq_vec[0];
  assign irq_evt = irq_vec[1];
endmodule

// File: tb/sim_spi_irq_agg.sv
module sim_spi_irq_agg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [5:0] rd_data;
  logic [5:0] err_pulse = '0;
  logic [5:0] evt_level = '0;
  logic       irq_err;
  logic       irq_evt;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_agg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .err_pulse(err_pulse), .evt_level(evt_level),
    .irq_err(irq_err), .irq_evt(irq_evt)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [5:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic pulse(input logic [5:0] p);
    @(negedge clk);
    err_pulse = p;
    @(negedge clk);
    err_pulse = '0;
  endtask

  task automatic t_reset();
    int v;
    reg_rd(0, v); check("R1 state", v, 0);
    reg_rd(1, v); check("R1 enable", v, 0);
    reg_rd(2, v); check("R1 test", v, 0);
    reg_rd(3, v); check("R1 err mask", v, 'h1F);
    reg_rd(4, v); check("R1 err status", v, 0);
    reg_rd(5, v); check("R1 evt mask", v, 0);
    check("R1 irq_err", int'(irq_err), 0);
    check("R1 irq_evt", int'(irq_evt), 0);
  endtask

  task automatic t_capture();
    int v;
    pulse(6'h20);
    reg_rd(4, v); check("R2 invalid-access captured", v, 'h20);
    tick(3);
    reg_rd(4, v); check("R2 status sticky", v, 'h20);
    reg_rd(0, v); check("R7 no pending while disabled", v, 0);
    check("R7 irq_err low", int'(irq_err), 0);
    reg_wr(4, 6'h20);
    reg_rd(4, v); check("R3 w1c clears", v, 0);
  endtask

  task automatic t_set_wins();
    int v;
    @(negedge clk);
    err_pulse = 6'h04; wr_en = 1'b1; wr_addr = 4; wr_data = 6'h04;
    @(negedge clk);
    err_pulse = '0; wr_en = 1'b0;
    reg_rd(4, v); check("R3 set beats clear", v, 'h04);
    reg_wr(4, 6'h04);
    reg_rd(4, v); check("R3 cleared after", v, 0);
  endtask

  task automatic t_err_irq();
    int v;
    reg_wr(1, 6'h01);
    pulse(6'h01);
    reg_rd(0, v); check("R4 not yet pending", v, 0);
    tick(1);
    reg_rd(0, v); check("R4 pending set", v, 1);
    check("R9 irq one cycle behind", int'(irq_err), 0);
    tick(1);
    check("R9 irq_err high", int'(irq_err), 1);
    reg_wr(4, 6'h01);
    tick(2);
    reg_rd(0, v); check("R8 pending after status clear", v, 1);
    check("R8 irq_err held", int'(irq_err), 1);
    reg_wr(0, 6'h01);
    reg_rd(0, v); check("R10 pending cleared", v, 0);
    tick(1);
    check("R9 irq_err dropped", int'(irq_err), 0);
    reg_rd(0, v); check("R10 no reraise without source", v, 0);
  endtask

  task automatic t_err_mask();
    int v;
    reg_wr(3, 6'h1E);
    pulse(6'h01);
    tick(3);
    reg_rd(4, v); check("R2 masked error still captured", v, 1);
    reg_rd(0, v); check("R4 masked error raises nothing", v, 0);
    check("R4 irq_err low", int'(irq_err), 0);
    reg_wr(4, 6'h01);
    reg_wr(3, 6'h1F);
  endtask

  task automatic t_event();
    int v;
    reg_wr(1, 6'h02);
    reg_wr(5, 6'h10);
    @(negedge clk); evt_level = 6'h01;
    tick(3);
    reg_rd(0, v); check("R5 unmasked event ignored", v, 0);
    evt_level = 6'h10;
    tick(1);
    reg_rd(0, v); check("R5 ready event pending", v, 2);
    tick(1);
    check("R5 irq_evt high", int'(irq_evt), 1);
    reg_wr(0, 6'h02);
    reg_rd(0, v); check("R10 cleared on write", v, 0);
    tick(1);
    reg_rd(0, v); check("R10 reraised by held level", v, 2);
    evt_level = '0;
    reg_wr(0, 6'h02);
    tick(3);
    reg_rd(0, v); check("R8 stays clear after source gone", v, 0);
    check("R8 irq_evt low", int'(irq_evt), 0);
  endtask

  task automatic t_test_disable();
    int v;
    reg_wr(1, 6'h01);
    reg_wr(2, 6'h01);
    reg_rd(0, v); check("R6 not yet pending", v, 0);
    tick(1);
    reg_rd(0, v); check("R6 test raises error class", v, 1);
    tick(1);
    check("R6 irq_err from test", int'(irq_err), 1);
    reg_wr(1, 6'h00);
    check("R9 irq holds on write cycle", int'(irq_err), 1);
    tick(1);
    check("R9 irq drops after disable", int'(irq_err), 0);
    reg_rd(0, v); check("R9 pending kept", v, 1);
    reg_wr(2, 6'h00);
    reg_wr(0, 6'h03);
    reg_wr(2, 6'h02);
    tick(3);
    reg_rd(0, v); check("R7 test ignored when disabled", v, 0);
    check("R7 irq_evt low", int'(irq_evt), 0);
    reg_wr(2, 6'h00);
  endtask

  task automatic t_unmapped();
    int v;
    for (int a = 6; a < 16; a++) reg_wr(4'(a), 6'h3F);
    tick(2);
    reg_rd(0, v); check("R11 state", v, 0);
    reg_rd(1, v); check("R11 enable", v, 0);
    reg_rd(2, v); check("R11 test", v, 0);
    reg_rd(3, v); check("R11 err mask", v, 'h1F);
    reg_rd(4, v); check("R11 err status", v, 0);
    reg_rd(5, v); check("R11 evt mask", v, 'h10);
    reg_rd(9, v); check("R11 unmapped reads zero", v, 0);
    check("R11 irq_err", int'(irq_err), 0);
    check("R11 irq_evt", int'(irq_evt), 0);
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_capture();
    t_set_wins();
    t_err_irq();
    t_err_mask();
    t_event();
    t_test_disable();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule